// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the configuration that decides who may see system-management memory, and it classifies every system memory access against that configuration. It keeps three fields: an SMRAM control byte, an extended control byte, and a 16-bit extended-size word. Software writes these fields through one 32-bit configuration port with byte enables. Writes are filtered through per-field write masks. A lock bit narrows those masks until the next reset.

On the access side, the block takes an address and an SMM indicator. It returns a two-bit route code. The legacy SMRAM window, its high alias near the top of 32-bit space, and a TSEG carve-out just below the end of low memory can each be sent to DRAM or to the PCI/VGA side, or turned into a black hole. The route is combinational from the stored state, so a configuration write governs every access presented on the cycle after that write's clock edge. The memory fabrics themselves lie outside this block.

Top module: `smram_access_ctrl`

## Requirements
- R1: After a synchronous reset, the SMRAM control byte and the extended control byte read 0x00, and the extended-size word reads 0xFFFF when EXT_MB is nonzero (0x0000 otherwise); the readback is {size word, extended byte, SMRAM byte} in bits 31:16, 15:8 and 7:0.
- R2: The SMRAM byte holds open (bit 0), lock (bit 1) and global enable (bit 2); the extended byte holds TSEG enable (bit 0), size code (bits 2:1) and high enable (bit 3); only these bits are writable, other bits read 0, and a byte lane changes only when its byte enable is set.
- R3: A write that leaves lock set forces open to 0; from then until reset, writes to both control bytes have no effect, while the size word stays writable.
- R4: Route codes are 0 = not claimed, 1 = DRAM, 2 = PCI/VGA, 3 = black hole; with open clear, a non-SMM access to the legacy window (0xA0000 to 0xBFFFF) routes to 2 and one to the high alias (0xFEDA0000 to 0xFEDBFFFF) routes to 0.
- R5: With open set, a non-SMM access routes legacy and high alias to 1 when high enable is set, and to 2 and 0 respectively when it is clear.
- R6: With global enable set, an SMM access routes the legacy window to 1 when high enable is clear and the high alias to 1 when it is set; otherwise SMM accesses to those windows follow the non-SMM rules.
- R7: With TSEG enable set, size code 0, 1, 2, 3 gives a TSEG of 1, 2, 8 or EXT_MB MiB; with it clear the TSEG size is 0 and nothing is claimed there.
- R8: An access in [LOW_MEM minus TSEG size, LOW_MEM) routes to 3 when non-SMM and 1 when SMM; the TSEG check takes priority over the other windows.
- R9: If a write leaves the size word equal to 0xFFFF and EXT_MB is nonzero, the word is replaced by EXT_MB; any other value written is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration readback |
| acc_addr | input | AW | Address of the memory access being classified |
| acc_smm | input | 1 | Access is issued in system management mode |
| acc_route | output | 2 | Route code for the access |

## Verification
The hardest state to reach is a locked configuration that still has interesting routing. Examples are global enable and high enable both set, or a TSEG size that came from the extended word. The lock freezes whatever was written before it. The stimulus therefore first programs a full routing configuration, then sets lock in a write that also sets open, and then keeps probing every window edge for both SMM values. Rejected writes are interleaved with those probes. A swept phase visits all 64 open/enable/size/high combinations before lock. A long pseudo-random phase then mixes partial byte-enable writes, occasional locks and the query word.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [1:0] {
    RT_PASS = 2'd0,
    RT_DRAM = 2'd1,
    RT_PCI  = 2'd2,
    RT_HOLE = 2'd3
  } route_e;

  // SMRAM control byte
  localparam int unsigned B_OPEN = 0;
  localparam int unsigned B_LOCK = 1;
  localparam int unsigned B_GEN  = 2;
  // extended control byte
  localparam int unsigned B_TSEN = 0;
  localparam int unsigned B_CODE = 1;
  localparam int unsigned B_HIGH = 3;

  localparam logic [7:0] SM_WMASK     = 8'h07;
  localparam logic [7:0] SM_WMASK_LCK = 8'h00;
  localparam logic [7:0] EX_WMASK     = 8'h0F;
  localparam logic [7:0] EX_WMASK_LCK = 8'h00;

  localparam logic [15:0] QUERY_WORD = 16'hFFFF;

endpackage

// File: rtl/sac_cfg_regs.sv
module sac_cfg_regs
  import sac_pkg::*;
#(
  parameter int unsigned EXT_MB = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [7:0]  sm_q,
  output logic [7:0]  ex_q,
  output logic [15:0] word_q
);

  localparam logic [15:0] WORD_RST = (EXT_MB > 0) ? QUERY_WORD : 16'h0000;
  localparam logic [15:0] EXT_WORD = 16'(EXT_MB);

  logic [7:0]  wm_sm, wm_ex, sm_mrg, sm_nx, ex_nx;
  logic [15:0] word_lane, word_nx;

  always_comb begin
    wm_sm  = sm_q[B_LOCK] ? SM_WMASK_LCK : SM_WMASK;
    wm_ex  = sm_q[B_LOCK] ? EX_WMASK_LCK : EX_WMASK;
    sm_mrg = be[0] ? ((wdata[7:0] & wm_sm) | (sm_q & ~wm_sm)) : sm_q;
    sm_nx  = sm_mrg;
    if (sm_mrg[B_LOCK]) sm_nx[B_OPEN] = 1'b0;
    ex_nx  = be[1] ? ((wdata[15:8] & wm_ex) | (ex_q & ~wm_ex)) : ex_q;
  end

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign word_lane[i*8 +: 8] = be[2+i] ? wdata[16 + i*8 +: 8] : word_q[i*8 +: 8];
  end

  assign word_nx = ((EXT_MB > 0) && (word_lane == QUERY_WORD)) ? EXT_WORD : word_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      sm_q   <= 8'h00;
      ex_q   <= 8'h00;
      word_q <= WORD_RST;
    end else if (wr) begin
      sm_q   <= sm_nx;
      ex_q   <= ex_nx;
      word_q <= word_nx;
    end
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sm_q[B_LOCK] |=> sm_q[B_LOCK]);

  // R3
  lock_closes_chk: assert property (@(posedge clk) disable iff (rst)
    sm_q[B_LOCK] |-> !sm_q[B_OPEN]);

  // R3
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    sm_q[B_LOCK] |=> $stable(ex_q));

  // R9
  query_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && be[3:2] == 2'b11 && wdata[31:16] == QUERY_WORD && EXT_MB > 0)
      |=> word_q == EXT_WORD);

endmodule

// File: rtl/sac_tseg_size.sv
module sac_tseg_size #(
  parameter int unsigned AW     = 32,
  parameter int unsigned EXT_MB = 16
) (
  input  logic          en,
  input  logic [1:0]    code,
  output logic [AW-1:0] size
);

  localparam int unsigned MIB_SH = 20;
  localparam logic [AW-1:0] ONE_MIB = AW'(1) << MIB_SH;
  localparam logic [AW-1:0] EXT_SZ  = AW'(EXT_MB) << MIB_SH;

  always_comb begin
    if (!en) begin
      size = '0;
    end else begin
      unique case (code)
        2'd0: size = ONE_MIB;
        2'd1: size = ONE_MIB << 1;
        2'd2: size = ONE_MIB << 3;
        default: size = EXT_SZ;
      endcase
    end
  end

endmodule

// File: rtl/sac_window_map.sv
module sac_window_map
  import sac_pkg::*;
#(
  parameter int unsigned    AW        = 32,
  parameter logic [AW-1:0]  LEG_BASE  = 32'h000A_0000,
  parameter logic [AW-1:0]  WIN_SIZE  = 32'h0002_0000,
  parameter logic [AW-1:0]  HIGH_BASE = 32'hFEDA_0000,
  parameter logic [AW-1:0]  LOW_MEM   = 32'h8000_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          smm,
  input  logic          open,
  input  logic          gen,
  input  logic          high,
  input  logic [AW-1:0] tseg_size,
  output route_e        route
);

  localparam logic [AW-1:0] LEG_END  = LEG_BASE + WIN_SIZE;
  localparam logic [AW-1:0] HIGH_END = HIGH_BASE + WIN_SIZE;

  logic [AW-1:0] tseg_base;
  logic in_leg, in_high, in_tseg, smm_low, smm_high, shown_open;

  always_comb begin
    tseg_base  = LOW_MEM - tseg_size;
    in_leg     = (addr >= LEG_BASE) && (addr < LEG_END);
    in_high    = (addr >= HIGH_BASE) && (addr < HIGH_END);
    in_tseg    = (tseg_size != '0) && (addr >= tseg_base) && (addr < LOW_MEM);
    smm_low    = smm && gen && !high;
    smm_high   = smm && gen && high;
    shown_open = open && high;

    if (in_tseg)
      route = smm ? RT_DRAM : RT_HOLE;
    else if (in_high)
      route = (smm_high || shown_open) ? RT_DRAM : RT_PASS;
    else if (in_leg)
      route = (smm_low || shown_open) ? RT_DRAM : RT_PCI;
    else
      route = RT_PASS;
  end

endmodule

// File: rtl/smram_access_ctrl.sv
module smram_access_ctrl
  import sac_pkg::*;
#(
  parameter int unsigned    AW        = 32,
  parameter int unsigned    EXT_MB    = 16,
  parameter logic [AW-1:0]  LEG_BASE  = 32'h000A_0000,
  parameter logic [AW-1:0]  WIN_SIZE  = 32'h0002_0000,
  parameter logic [AW-1:0]  HIGH_BASE = 32'hFEDA_0000,
  parameter logic [AW-1:0]  LOW_MEM   = 32'h8000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_smm,
  output logic [1:0]    acc_route
);

  logic [7:0]    sm_q, ex_q;
  logic [15:0]   word_q;
  logic [AW-1:0] tseg_size;
  route_e        route;

  sac_cfg_regs #(.EXT_MB(EXT_MB)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .be(cfg_be), .wdata(cfg_wdata),
    .sm_q(sm_q), .ex_q(ex_q), .word_q(word_q)
  );

  sac_tseg_size #(.AW(AW), .EXT_MB(EXT_MB)) u_tsz (
    .en(ex_q[B_TSEN]), .code(ex_q[B_CODE +: 2]), .size(tseg_size)
  );

  sac_window_map #(
    .AW(AW), .LEG_BASE(LEG_BASE), .WIN_SIZE(WIN_SIZE),
    .HIGH_BASE(HIGH_BASE), .LOW_MEM(LOW_MEM)
  ) u_map (
    .addr(acc_addr), .smm(acc_smm), .open(sm_q[B_OPEN]), .gen(sm_q[B_GEN]),
    .high(ex_q[B_HIGH]), .tseg_size(tseg_size), .route(route)
  );

  assign cfg_rdata = {word_q, ex_q, sm_q};
  assign acc_route = route;

  // R8
  smm_no_hole_chk: assert property (@(posedge clk) disable iff (rst)
    acc_smm |-> acc_route != RT_HOLE);

  // R4
  closed_no_dram_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_smm && !sm_q[B_OPEN]) |-> acc_route != RT_DRAM);

  // R5
  open_low_no_dram_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_smm && sm_q[B_OPEN] && !ex_q[B_HIGH]) |-> acc_route != RT_DRAM);

endmodule

// File: tb/smram_access_ctrl_bench.sv
module smram_access_ctrl_bench;

  localparam int unsigned AW     = 32;
  localparam int unsigned EXT_MB = 16;
  localparam logic [31:0] LOW_MEM = 32'h8000_0000;
  localparam logic [31:0] MIB     = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_smm = 1'b0;
  logic [1:0]  acc_route;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  smram_access_ctrl #(.AW(AW), .EXT_MB(EXT_MB), .LOW_MEM(LOW_MEM)) u_smram_access_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_route(acc_route)
  );

  // reference model state
  bit m_open, m_lock, m_gen, m_tsen, m_high;
  bit [1:0] m_code;
  bit [15:0] m_word;

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_lock = 0; m_gen = 0; m_tsen = 0; m_high = 0; m_code = 0;
      m_word = (EXT_MB > 0) ? 16'hFFFF : 16'h0000;
    end else if (cfg_wr) begin
      if (!m_lock && cfg_be[1]) begin
        m_tsen = cfg_wdata[8]; m_code = cfg_wdata[10:9]; m_high = cfg_wdata[11];
      end
      if (!m_lock && cfg_be[0]) begin
        m_open = cfg_wdata[0]; m_lock = cfg_wdata[1]; m_gen = cfg_wdata[2];
      end
      if (m_lock) m_open = 0;
      if (cfg_be[2]) m_word[7:0]  = cfg_wdata[23:16];
      if (cfg_be[3]) m_word[15:8] = cfg_wdata[31:24];
      if (EXT_MB > 0 && m_word == 16'hFFFF) m_word = 16'(EXT_MB);
    end
  end

  function automatic logic [31:0] m_tsize();
    if (!m_tsen) return 0;
    case (m_code)
      2'd0: return MIB;
      2'd1: return 2 * MIB;
      2'd2: return 8 * MIB;
      default: return EXT_MB * MIB;
    endcase
  endfunction

  function automatic int m_route(input logic [31:0] a, input bit smm);
    logic [31:0] sz = m_tsize();
    bit in_t = (sz != 0) && (a >= LOW_MEM - sz) && (a < LOW_MEM);
    bit in_h = (a >= 32'hFEDA_0000) && (a <= 32'hFEDB_FFFF);
    bit in_l = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    if (in_t) return smm ? 1 : 3;
    if (in_h) begin
      if (smm && m_gen && m_high) return 1;
      if (m_open && m_high) return 1;
      return 0;
    end
    if (in_l) begin
      if (smm && m_gen && !m_high) return 1;
      if (m_open && m_high) return 1;
      return 2;
    end
    return 0;
  endfunction

  function automatic string m_tag(input logic [31:0] a, input bit smm);
    bit near_t = (a >= LOW_MEM - 17 * MIB) && (a <= LOW_MEM);
    bit win = (a >= 32'hFEDA_0000 && a <= 32'hFEDB_FFFF) ||
              (a >= 32'h000A_0000 && a <= 32'h000B_FFFF);
    if (near_t) return "R7/R8";
    if (win && smm && m_gen) return "R6";
    if (win && m_open) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (addr 0x%08h smm %0d)",
               req, act, exp, acc_addr, acc_smm);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3/R9", cfg_rdata,
          {m_word, 4'h0, m_high, m_code, m_tsen, 5'h0, m_gen, m_lock, m_open});
      chk(m_tag(acc_addr, acc_smm), 32'(acc_route), 32'(m_route(acc_addr, acc_smm)));
    end
  end

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: return 32'h000A_0000;   1: return 32'h000B_FFFF;
      2: return 32'h0009_FFFF;   3: return 32'h000C_0000;
      4: return 32'hFEDA_0000;   5: return 32'hFEDB_FFFF;
      6: return 32'hFEDC_0000;   7: return LOW_MEM - MIB;
      8: return LOW_MEM - MIB - 1; 9: return LOW_MEM - 2 * MIB;
      10: return LOW_MEM - 8 * MIB; 11: return LOW_MEM - 16 * MIB;
      12: return LOW_MEM - 16 * MIB - 1; 13: return LOW_MEM - 1;
      default: return LOW_MEM;
    endcase
  endfunction

  task automatic do_wr(input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic sweep_probes();
    for (int k = 0; k < 15; k++) begin
      for (int s = 0; s < 2; s++) begin
        acc_addr = pick(k); acc_smm = s[0];
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    bit [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    acc_addr = 32'h000A_0000; acc_smm = 0;
    @(negedge clk);
    chk("R1", cfg_rdata, 32'hFFFF_0000);
    chk("R1", 32'(acc_route), 32'd2);
    @(posedge clk); #1;

    // sweep every unlocked configuration
    for (int c = 0; c < 64; c++) begin
      do_wr(4'b0011, {16'h0, 4'h0, c[5:2], 5'h0, c[1], 1'b0, c[0]});
      sweep_probes();
    end

    // extended size word and query
    do_wr(4'b1100, 32'hFFFF_0000);
    do_wr(4'b1100, 32'h1234_0000);
    do_wr(4'b1000, 32'hFF00_0000);
    do_wr(4'b0100, 32'h00FF_0000);
    do_wr(4'b0011, 32'h0000_0F04);   // extended TSEG, high on, global on
    sweep_probes();

    // lock together with open: open must drop, bytes freeze
    do_wr(4'b0001, 32'h0000_0007);
    sweep_probes();
    do_wr(4'b0011, 32'h0000_0000);
    sweep_probes();
    do_wr(4'b1111, 32'h0055_0101);
    do_wr(4'b1100, 32'hFFFF_0000);
    sweep_probes();

    // reset clears lock
    rst = 1; @(posedge clk); @(posedge clk); #1 rst = 0;
    acc_addr = 32'hFEDA_0000; acc_smm = 0;
    @(negedge clk);
    chk("R1", cfg_rdata, 32'hFFFF_0000);
    chk("R1", 32'(acc_route), 32'd0);
    @(posedge clk); #1;

    // pseudo-random mix
    for (int n = 0; n < 3000; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      acc_smm = lf[0];
      acc_addr = lf[1] ? pick(int'(lf[7:4]) % 15) + {28'h0, lf[11:8]} : lf;
      if (lf[14:12] == 3'd0) begin
        cfg_wr = 1; cfg_be = lf[19:16];
        cfg_wdata = {lf[20] ? 16'hFFFF : lf[31:16], lf[27:20],
                     lf[31:26], (lf[25:21] == 0), lf[15]};
      end else begin
        cfg_wr = 0;
      end
      @(posedge clk); #1;
      cfg_wr = 0;
      if (n % 700 == 699) begin
        rst = 1; @(posedge clk); #1 rst = 0;
      end
    end
    finish_run();
  end

endmodule